// File: doc/BRIEF.md
# Indexed Host Register Decoder

This block sits behind a four-byte host I/O window and opens a 256-entry internal register space through an index. The host writes an index byte at offset 0. Offset 1 then reads or writes whichever register that index names. Offsets 2 and 3 bypass the index for converter traffic. Reads there return the latest ADC result. Writes there load one of two DAC codes, and the current index picks the DAC.

The converters, the counter/timer and the digital I/O lines live outside. They connect through plain ports: a conversion-done pulse and result bus, a timer channel 1 output, and a small forwarding port for the indexed registers kept outside the block. Inside, the block holds the index, the multiplexer channel select, the user LED bit, staging and output registers for both DAC codes, a fixed identifier, and two pending-interrupt latches. The two latches are merged into a single interrupt request.

Top module: `idx_host_regs`

## Requirements
- R1: Offset 0 is write-only and loads the 8-bit index; a read at offset 0 returns 00h. After reset the index is 00h.
- R2: With index 81h, a read at offset 1 returns 2Dh. Writes to that index change nothing.
- R3: With index 80h, bit 0 of an offset-1 write sets the user LED (1 = on). A read returns the LED bit in bit 0 and zeros above it.
- R4: With index 02h (DAC A) or 03h (DAC B), a write at offset 2 stages data bits 7:4 as code bits 3:0. A later offset-3 write commits the code {data[7:0], staged nibble}. The DAC output changes only on that offset-3 write.
- R5: Offset 2 and 3 writes while the index is neither 02h nor 03h leave both DAC outputs unchanged.
- R6: A read at offset 2 returns {0000, result[3:0]}. A read at offset 3 returns result[11:4]. A conversion-done pulse makes status bit 0 read 0, and a read strobe at offset 3 returns it to 1. If a done pulse and that read fall in the same cycle, the pulse wins.
- R7: Status is read at index 00h. A rising edge on the timer channel 1 output makes status bit 1 read 0 three clock edges after the input changes. The edge passes a two-flop synchroniser first. Any offset-1 write with index 08h returns the bit to 1, unless a new edge lands in that same cycle.
- R8: irq is high whenever either status bit 0 or status bit 1 reads 0.
- R9: Indexes 0Ch–7Fh and 82h–FFh, and index 02h, 03h and 08h at offset 1, read 00h. Offset-1 writes to the unused ranges change no register.
- R10: With index 01h, an offset-1 write loads the 4-bit multiplexer select from data bits 3:0. A read returns it in bits 3:0.
- R11: An offset-1 write with index 00h raises adc_start for exactly the cycle of that write.
- R12: Indexes 04h–07h and 09h–0Bh are forwarded. ext_idx carries index bits 3:0, ext_wr marks an offset-1 write to them, and offset-1 reads return ext_rdata.
- R13: After reset the LED, the multiplexer select and both DAC codes are zero, status reads 03h, and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_addr | input | 2 | Host byte offset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (used for the offset-3 clear) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational from offset and index |
| adc_result | input | 12 | Latest conversion result |
| adc_done | input | 1 | Conversion-complete pulse |
| adc_start | output | 1 | Software conversion trigger |
| mux_sel | output | 4 | Analogue multiplexer channel |
| dac_a | output | 12 | DAC A code |
| dac_b | output | 12 | DAC B code |
| tmr1_out | input | 1 | Timer channel 1 output, asynchronous |
| ext_idx | output | 4 | Index of a forwarded register |
| ext_wr | output | 1 | Write strobe for a forwarded register |
| ext_rdata | input | 8 | Read data of the forwarded register |
| user_led | output | 1 | User LED drive |
| irq | output | 1 | Combined interrupt request |

## Verification
The index is swept through every class of register: status, multiplexer select, LED, identifier, DAC selectors, the clear strobe, forwarded entries and both unused ranges. A wrong decode therefore shows up as a bad readback or a side effect on another register. DAC traffic is tried with the index on each DAC and on a non-DAC value, and the output is checked between the two byte writes, which separates staging from commit and DAC A from DAC B. Each interrupt source is raised alone, cleared alone, and then raised in the very cycle of its clear. This separates set-wins from clear-wins, and shows that each clear touches only its own source.

// File: rtl/idx_host_regs.sv
`timescale 1ns/1ps
module idx_host_regs #(
  parameter logic [7:0] BOARD_ID = 8'h2D,
  parameter int MUX_W = 4,
  parameter int SYNC_STAGES = 2
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       host_addr,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata,
  input  logic [11:0]      adc_result,
  input  logic             adc_done,
  output logic             adc_start,
  output logic [MUX_W-1:0] mux_sel,
  output logic [11:0]      dac_a,
  output logic [11:0]      dac_b,
  input  logic             tmr1_out,
  output logic [3:0]       ext_idx,
  output logic             ext_wr,
  input  logic [7:0]       ext_rdata,
  output logic             user_led,
  output logic             irq
);
  localparam logic [7:0] I_STAT = 8'h00, I_MUX = 8'h01, I_DACA = 8'h02,
                         I_DACB = 8'h03, I_TCLR = 8'h08, I_LED = 8'h80, I_ID = 8'h81;

  logic [7:0] idx;
  logic [3:0] stage_a, stage_b;
  logic [SYNC_STAGES:0] tsync;
  logic adc_pend, tmr_pend, tmr_rise, is_ext;

  wire wr_idx = host_wr && host_addr == 2'd0;
  wire wr_reg = host_wr && host_addr == 2'd1;
  wire wr_lo  = host_wr && host_addr == 2'd2;
  wire wr_hi  = host_wr && host_addr == 2'd3;

  assign is_ext   = idx[7:4] == 4'h0 && (idx[3:2] == 2'b01 || (idx[3:0] >= 4'h9 && idx[3:0] <= 4'hB));
  assign ext_idx  = idx[3:0];
  assign ext_wr   = wr_reg && is_ext;
  assign adc_start = wr_reg && idx == I_STAT;
  assign tmr_rise = tsync[SYNC_STAGES-1] && !tsync[SYNC_STAGES];
  assign irq      = adc_pend || tmr_pend;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      idx <= '0; mux_sel <= '0; user_led <= 1'b0;
      stage_a <= '0; stage_b <= '0; dac_a <= '0; dac_b <= '0;
    end else begin
      if (wr_idx) idx <= host_wdata;
      if (wr_reg && idx == I_MUX) mux_sel <= host_wdata[MUX_W-1:0];
      if (wr_reg && idx == I_LED) user_led <= host_wdata[0];
      if (wr_lo && idx == I_DACA) stage_a <= host_wdata[7:4];
      if (wr_lo && idx == I_DACB) stage_b <= host_wdata[7:4];
      if (wr_hi && idx == I_DACA) dac_a <= {host_wdata, stage_a};
      if (wr_hi && idx == I_DACB) dac_b <= {host_wdata, stage_b};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tsync <= '0; adc_pend <= 1'b0; tmr_pend <= 1'b0;
    end else begin
      tsync <= {tsync[SYNC_STAGES-1:0], tmr1_out};
      if (adc_done) adc_pend <= 1'b1;
      else if (host_rd && host_addr == 2'd3) adc_pend <= 1'b0;
      if (tmr_rise) tmr_pend <= 1'b1;
      else if (wr_reg && idx == I_TCLR) tmr_pend <= 1'b0;
    end

  always_comb begin
    host_rdata = 8'h00;
    case (host_addr)
      2'd1:
        if (idx == I_STAT)     host_rdata = {6'b0, !tmr_pend, !adc_pend};
        else if (idx == I_MUX) host_rdata = 8'(mux_sel);
        else if (idx == I_LED) host_rdata = {7'b0, user_led};
        else if (idx == I_ID)  host_rdata = BOARD_ID;
        else if (is_ext)       host_rdata = ext_rdata;
      2'd2: host_rdata = {4'h0, adc_result[3:0]};
      2'd3: host_rdata = adc_result[11:4];
      default: host_rdata = 8'h00;
    endcase
  end
endmodule

module idx_host_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  host_addr,
  input logic        host_wr,
  input logic [7:0]  host_rdata,
  input logic [7:0]  idx,
  input logic        adc_done,
  input logic        adc_pend,
  input logic        tmr_rise,
  input logic        tmr_pend,
  input logic        irq,
  input logic [11:0] dac_a,
  input logic [11:0] dac_b
);
  a_r1_offset0_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    host_addr == 2'd0 |-> host_rdata == 8'h00);
  a_r2_board_id: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == 2'd1 && idx == 8'h81) |-> host_rdata == 8'h2D);
  a_r4_dac_a_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_a) |-> $past(host_wr && host_addr == 2'd3 && idx == 8'h02));
  a_r5_dac_b_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_b) |-> $past(host_wr && host_addr == 2'd3 && idx == 8'h03));
  a_r6_adc_sets: assert property (@(posedge clk) disable iff (!rst_n)
    adc_done |=> adc_pend);
  a_r7_tmr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 2'd1 && idx == 8'h08 && !tmr_rise) |=> !tmr_pend);
  a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(adc_done || tmr_rise));
  a_r9_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == 2'd1 && idx >= 8'h0C && idx <= 8'h7F) |-> host_rdata == 8'h00);
endmodule

bind idx_host_regs idx_host_regs_chk chk (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
  .host_rdata(host_rdata), .idx(idx), .adc_done(adc_done), .adc_pend(adc_pend),
  .tmr_rise(tmr_rise), .tmr_pend(tmr_pend), .irq(irq), .dac_a(dac_a), .dac_b(dac_b));

// File: tb/idx_host_regs_test.sv
`timescale 1ns/1ps
module idx_host_regs_test;
  logic clk = 0, rst_n = 0;
  logic [1:0] host_addr = 0;
  logic host_wr = 0, host_rd = 0;
  logic [7:0] host_wdata = 0, host_rdata;
  logic [11:0] adc_result = 0;
  logic adc_done = 0, adc_start;
  logic [3:0] mux_sel, ext_idx;
  logic [11:0] dac_a, dac_b;
  logic tmr1_out = 0, ext_wr, user_led, irq;
  logic [7:0] ext_rdata;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  assign ext_rdata = {4'hA, ext_idx};

  idx_host_regs uut (.clk, .rst_n, .host_addr, .host_wr, .host_rd, .host_wdata,
    .host_rdata, .adc_result, .adc_done, .adc_start, .mux_sel, .dac_a, .dac_b,
    .tmr1_out, .ext_idx, .ext_wr, .ext_rdata, .user_led, .irq);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); host_addr = a; host_rd = 1; #1 d = host_rdata;
    @(negedge clk); host_rd = 0;
  endtask

  task automatic rd_idx(logic [7:0] i, output logic [7:0] d);
    wr(0, i); rd(1, d);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R13 led", user_led, 0); check("R13 mux", mux_sel, 0);
    check("R13 dac_a", dac_a, 0); check("R13 dac_b", dac_b, 0);
    check("R13 irq", irq, 0);
    rd(1, d); check("R13 status (R1 index 00)", d, 8'h03);
    rd(0, d); check("R1 offset0 read", d, 0);
  endtask

  task automatic t_id_led_mux;
    logic [7:0] d;
    rd_idx(8'h81, d); check("R2 id", d, 8'h2D);
    wr(1, 8'h00); rd(1, d); check("R2 id after write", d, 8'h2D);
    wr(0, 8'h80); wr(1, 8'hFF); check("R3 led on", user_led, 1);
    rd(1, d); check("R3 led read", d, 8'h01);
    wr(1, 8'hFE); check("R3 led off", user_led, 0);
    wr(1, 8'h01);
    wr(0, 8'h01); wr(1, 8'hF9); check("R10 mux", mux_sel, 4'h9);
    rd(1, d); check("R10 mux read", d, 8'h09);
  endtask

  task automatic t_dac;
    wr(0, 8'h02); wr(2, 8'h7C);
    check("R4 dac_a held after low", dac_a, 0);
    wr(3, 8'hAB); check("R4 dac_a commit", dac_a, 12'hAB7);
    wr(0, 8'h03); wr(2, 8'h50);
    check("R4 dac_b held after low", dac_b, 0);
    wr(3, 8'h12); check("R4 dac_b commit", dac_b, 12'h125);
    check("R4 dac_a untouched by B", dac_a, 12'hAB7);
    wr(3, 8'h34); check("R4 dac_b restaged nibble", dac_b, 12'h345);
  endtask

  task automatic t_dac_ignore;
    wr(0, 8'h01); wr(2, 8'hF0); wr(3, 8'hFF);
    check("R5 dac_a ignored", dac_a, 12'hAB7);
    check("R5 dac_b ignored", dac_b, 12'h345);
    check("R5 mux unaffected", mux_sel, 4'h9);
  endtask

  task automatic t_adc;
    logic [7:0] d;
    adc_result = 12'hA5C;
    @(negedge clk); adc_done = 1; @(negedge clk); adc_done = 0;
    check("R8 irq adc", irq, 1);
    rd_idx(8'h00, d); check("R6 status adc pending", d, 8'h02);
    rd(2, d); check("R6 low nibble", d, 8'h0C);
    rd(3, d); check("R6 high byte", d, 8'hA5);
    rd(1, d); check("R6 status cleared", d, 8'h03);
    check("R8 irq low", irq, 0);
    @(negedge clk); adc_done = 1; host_addr = 3; host_rd = 1;
    @(negedge clk); adc_done = 0; host_rd = 0;
    rd(1, d); check("R6 set wins over read", d, 8'h02);
    rd(3, d); rd(1, d); check("R6 cleared again", d, 8'h03);
  endtask

  task automatic t_timer;
    logic [7:0] d;
    wr(0, 8'h00);
    @(negedge clk); tmr1_out = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); check("R7 not yet after two edges", irq, 0);
    @(negedge clk); check("R8 irq timer", irq, 1);
    rd(1, d); check("R7 status timer pending", d, 8'h01);
    wr(0, 8'h08); wr(1, 8'h5A);
    check("R7 cleared", irq, 0);
    repeat (4) @(negedge clk);
    check("R7 level does not retrigger", irq, 0);
    tmr1_out = 0; repeat (4) @(negedge clk);
    tmr1_out = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); host_addr = 1; host_wdata = 0; host_wr = 1;
    @(negedge clk); host_wr = 0;
    check("R7 set wins over clear", irq, 1);
    wr(1, 8'h00); check("R7 clear after", irq, 0);
    tmr1_out = 0;
  endtask

  task automatic t_unused;
    logic [7:0] d;
    rd_idx(8'h0C, d); check("R9 0C read", d, 0);
    rd_idx(8'h7F, d); check("R9 7F read", d, 0);
    rd_idx(8'hC3, d); check("R9 C3 read", d, 0);
    rd_idx(8'h02, d); check("R9 02 at offset1", d, 0);
    wr(0, 8'h40); wr(1, 8'hFF); wr(0, 8'hC1); wr(1, 8'h00);
    check("R9 led kept", user_led, 1);
    check("R9 mux kept", mux_sel, 4'h9);
    check("R9 irq kept", irq, 0);
  endtask

  task automatic t_strobes;
    logic [7:0] d;
    wr(0, 8'h00);
    @(negedge clk); host_addr = 1; host_wdata = 8'h77; host_wr = 1;
    #1 check("R11 adc_start high", adc_start, 1);
    check("R12 ext_wr low at 00", ext_wr, 0);
    @(negedge clk); host_wr = 0;
    #1 check("R11 adc_start one cycle", adc_start, 0);
    wr(0, 8'h0A);
    @(negedge clk); host_addr = 1; host_wr = 1;
    #1 check("R12 ext_wr", ext_wr, 1); check("R12 ext_idx", ext_idx, 4'hA);
    @(negedge clk); host_wr = 0;
    rd(1, d); check("R12 ext read", d, 8'hAA);
    rd_idx(8'h05, d); check("R12 ext read 05", d, 8'hA5);
    rd_idx(8'h08, d); check("R12/R9 08 not forwarded", d, 0);
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_id_led_mux;
    t_dac;
    t_dac_ignore;
    t_adc;
    t_timer;
    t_unused;
    t_strobes;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule